// File: doc/BRIEF.md
# Carry-Free Low-Half Approximate Adder

This block adds two unsigned N-bit operands but only guarantees an exact result in the upper bits. The operands are cut at bit K: the N-K upper bits go through an exact ripple-carry adder, and the K lower bits go through a carry-free cell row. No carry is created or consumed in the lower bits, and no carry crosses from the lower bits into the upper bits. Cutting the carry chain this way keeps the longest path short. The cost is a bounded error in the low part of the result.

The lower bits are read from their most significant position downward. At every position above the highest place where both operand bits are 1, the sum bit is the XOR of the two operand bits. From that place down to bit 0, every sum bit is set to 1. A per-bit mode signal selects between XOR and forced-1. This signal is built by a chain split into groups. The entry of each group is fed straight from the groups above it, so a forced-1 does not ripple through every cell.

The block is purely combinational. It is intended for datapaths such as pixel or audio arithmetic, where a small error in the low-order bits is acceptable.

Top module: `eta_adder`

## Requirements
- R1: Lower bits that sit above the highest position where both operand bits are 1 give sum bit = a XOR b.
- R2: At the highest lower-part position where both operand bits are 1, that sum bit and every lower sum bit are 1.
- R3: When no lower-part position has both operand bits at 1, the low K sum bits equal a XOR b exactly.
- R4: The upper N-K sum bits, with carry_o as their most significant bit, equal the exact sum of the upper operand fields. Lower bits never change them.
- R5: carry_o is the carry out of the upper-part addition. The full approximate result is carry_o·2^N + sum_o.
- R6: With N=16 and K=8, the inputs 45978 and 26899 give sum_o = 0x1C9F and carry_o = 1. That is a total of 72863, which is 14 below the exact sum.
- R7: The outputs depend only on the present inputs. There is no clock and no state.
- R8: The result is the same for any control-group size, including groups that do not divide K evenly.
- R9: Corner cases: all-zero inputs give 0. All-ones inputs give the same result as the bit model. Operands whose only common 1 is bit 0 give sum 1, which is an error of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N_W | First operand |
| b_i | input | N_W | Second operand |
| sum_o | output | N_W | Approximate sum: exact upper part, carry-free lower part |
| carry_o | output | 1 | Carry out of the upper-part adder |

## Verification
A broken group link or a stuck mode bit shows up in one of two ways. A run of low sum bits is not forced to 1 below a common 1, or XOR bits below that point survive. A broken upper adder gives a wrong upper field or carry. Because the block holds no state, a fault appears on the ports in the same evaluation as the input that triggers it. An exhaustive sweep of an 8-bit build, repeated with two group sizes, therefore reaches every mode pattern of the chain.

// File: rtl/eta_pkg.sv
package eta_pkg;
  function automatic int unsigned ceil_div(input int unsigned x, input int unsigned y);
    return (x + y - 1) / y;
  endfunction
endpackage

// File: rtl/eta_rca_exact.sv
module eta_rca_exact #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign carry_o = c[W];

  always_comb begin
    p_exact_hi_r4: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("upper part inexact");
  end
endmodule

// File: rtl/eta_ctl_chain.sv
module eta_ctl_chain
  import eta_pkg::*;
#(
  parameter int unsigned K   = 20,
  parameter int unsigned GRP = 5
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  output logic [K-1:0] ctl_o
);
  localparam int unsigned NGRP = ceil_div(K, GRP);

  logic [K-1:0]    dbl;
  logic [NGRP-1:0] grp_any;
  logic [NGRP-1:0] enter;

  assign dbl = a_i & b_i;

  // group 0 holds the MSBs of the lower part
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int HI = int'(K) - 1 - g * int'(GRP);
    localparam int LO = (HI - int'(GRP) + 1 < 0) ? 0 : HI - int'(GRP) + 1;
    assign grp_any[g] = |dbl[HI:LO];
    if (g == 0) begin : g_first
      assign enter[g] = 1'b0;
    end else begin : g_next
      assign enter[g] = enter[g-1] | grp_any[g-1];
    end
  end

  for (genvar i = 0; i < K; i++) begin : g_cell
    localparam int G_IDX = (int'(K) - 1 - i) / int'(GRP);
    localparam int TOP   = int'(K) - 1 - G_IDX * int'(GRP);
    if (i == TOP) begin : g_lead
      assign ctl_o[i] = enter[G_IDX] | dbl[i];
    end else begin : g_rip
      assign ctl_o[i] = ctl_o[i+1] | dbl[i];
    end
  end

  always_comb begin
    for (int i = 0; i < int'(K); i++) begin
      p_ctl_covers_dbl_r2: assert (!dbl[i] || ctl_o[i])
        else $error("mode bit missing at common one");
    end
    for (int i = 0; i + 1 < int'(K); i++) begin
      p_ctl_monotone_r2: assert (!ctl_o[i+1] || ctl_o[i])
        else $error("mode bit not carried down");
    end
  end
endmodule

// File: rtl/eta_sum_cells.sv
module eta_sum_cells #(
  parameter int unsigned K = 20
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  input  logic [K-1:0] ctl_i,
  output logic [K-1:0] sum_o
);
  for (genvar i = 0; i < K; i++) begin : g_cell
    assign sum_o[i] = ctl_i[i] ? 1'b1 : (a_i[i] ^ b_i[i]);
  end
endmodule

// File: rtl/eta_adder.sv
module eta_adder #(
  parameter int unsigned N_W   = 32,
  parameter int unsigned K_W   = 20,
  parameter int unsigned GRP_W = 5
) (
  input  logic [N_W-1:0] a_i,
  input  logic [N_W-1:0] b_i,
  output logic [N_W-1:0] sum_o,
  output logic           carry_o
);
  localparam int unsigned A_W = N_W - K_W;

  logic [K_W-1:0] a_lo, b_lo, ctl, sum_lo;
  logic [A_W-1:0] a_hi, b_hi, sum_hi;

  assign a_lo = a_i[K_W-1:0];
  assign b_lo = b_i[K_W-1:0];
  assign a_hi = a_i[N_W-1:K_W];
  assign b_hi = b_i[N_W-1:K_W];

  eta_rca_exact #(.W(A_W)) u_hi (
    .a_i(a_hi), .b_i(b_hi), .sum_o(sum_hi), .carry_o(carry_o)
  );

  eta_ctl_chain #(.K(K_W), .GRP(GRP_W)) u_ctl (
    .a_i(a_lo), .b_i(b_lo), .ctl_o(ctl)
  );

  eta_sum_cells #(.K(K_W)) u_lo (
    .a_i(a_lo), .b_i(b_lo), .ctl_i(ctl), .sum_o(sum_lo)
  );

  assign sum_o = {sum_hi, sum_lo};

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = int'(K_W) - 1; i >= 0; i--) begin
      if (a_lo[i] & b_lo[i]) seen = 1'b1;
      if (seen) begin
        p_first_dbl_r2: assert (sum_lo[i])
          else $error("bit below common one not forced");
      end else begin
        p_above_xor_r1: assert (sum_lo[i] == (a_lo[i] ^ b_lo[i]))
          else $error("bit above common one not xor");
      end
    end
    p_clear_low_r3: assert (|(a_lo & b_lo) || (sum_lo == (a_lo ^ b_lo)))
      else $error("low part altered without common one");
  end
endmodule

// File: tb/tb_eta_adder.sv
module tb_eta_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0]  a8, b8;
  logic [7:0]  s8, s8g;
  logic        c8, c8g;
  logic [15:0] a16, b16, s16;
  logic        c16;
  logic [31:0] a32, b32, s32;
  logic        c32;

  eta_adder #(.N_W(8), .K_W(5), .GRP_W(2)) dut (
    .a_i(a8), .b_i(b8), .sum_o(s8), .carry_o(c8));
  eta_adder #(.N_W(8), .K_W(5), .GRP_W(3)) dut_g3 (
    .a_i(a8), .b_i(b8), .sum_o(s8g), .carry_o(c8g));
  eta_adder #(.N_W(16), .K_W(8), .GRP_W(4)) dut16 (
    .a_i(a16), .b_i(b16), .sum_o(s16), .carry_o(c16));
  eta_adder dut32 (
    .a_i(a32), .b_i(b32), .sum_o(s32), .carry_o(c32));

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input int n, input int k);
    logic [63:0] m, hi, lo;
    bit forced;
    m  = (64'd1 << (n - k)) - 64'd1;
    hi = ((a >> k) & m) + ((b >> k) & m);
    lo = '0;
    forced = 1'b0;
    for (int i = k - 1; i >= 0; i--) begin
      if (a[i] & b[i]) forced = 1'b1;
      lo[i] = forced | (a[i] ^ b[i]);
    end
    return (hi << k) | lo;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    logic [63:0] e, r;
    int maxerr;
    a8 = '0; b8 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0;
    @(negedge clk); #2;
    // R7 R9 zero inputs
    check("R9 zero", {c32, s32}, 64'd0);
    check("R9 zero narrow", {c8, s8}, 64'd0);

    // R1 R2 R3 R4 R5 R8: exhaustive 8-bit, K=5, two group sizes
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        a8 = 8'(a); b8 = 8'(b);
        #2;
        e = model(64'(a), 64'(b), 8, 5);
        check("R1/R2/R3/R4/R5 sweep", {c8, s8}, e);
        check("R8 group size", {c8g, s8g}, {c8, s8});
      end
    end

    // R6 worked example
    @(negedge clk);
    a16 = 16'd45978; b16 = 16'd26899;
    #2;
    check("R6 sum", 64'(s16), 64'h1C9F);
    check("R6 carry", 64'(c16), 64'd1);
    check("R6 error", 64'(72877) - {c16, s16}, 64'd14);
    $display("16-bit example: approx %0d exact 72877", {c16, s16});

    // R9 corners on the default build
    @(negedge clk);
    a32 = '1; b32 = '1;
    #2;
    check("R9 all ones", {c32, s32}, model({32'd0, a32}, {32'd0, b32}, 32, 20));
    $display("all ones: error %0d", (64'h1FFFFFFFE) - {c32, s32});
    @(negedge clk);
    a32 = 32'd1; b32 = 32'd1;
    #2;
    check("R9 lsb only", {c32, s32}, 64'd1);
    $display("lsb double one: error %0d", 64'd2 - {c32, s32});

    // R4 lower bits do not disturb upper part
    @(negedge clk);
    a32 = 32'h0010_0000 | 32'h000F_FFFF; b32 = 32'h000F_FFFF;
    #2;
    check("R4 no carry into upper", 64'({c32, s32[31:20]}), 64'h001);
    check("R2 low forced", 64'(s32[19:0]), 64'hFFFFF);

    // random on default build
    maxerr = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      a32 = $urandom; b32 = $urandom;
      #2;
      r = {31'd0, c32, s32};
      check("R1/R2/R4/R5 random", r, model({32'd0, a32}, {32'd0, b32}, 32, 20));
      e = 64'(a32) + 64'(b32);
      if (int'(e - r) > maxerr) maxerr = int'(e - r);
    end
    $display("random 32-bit: max overall error %0d", maxerr);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_200_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule